// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a serial access path from a JTAG test access port into a small bank of on-chip debug registers. A TAP controller outside the block supplies the data-register state strobes, the current instruction and the number of the chain chosen by the chain-select instruction. The block responds only when its own chain number is chosen and the TAP holds the internal-test instruction. At all other times it ignores every strobe and keeps its serial output low.

The serial word is 38 bits long and carries one complete access command. Bits 31:0 hold the data. Bits 36:32 hold the register address. Bit 37 sets the direction. Data moves in from TDI and out on TDO, least significant bit first. The access itself takes place in the update-DR state. A write copies bits 31:0 into the addressed register. A read loads that register into bits 31:0 of the shift register, and the next shift sequence carries the value out.

The register bank has its own system reset. A TAP reset clears only the serial register, so the debug state survives a reset of the debug port. The register contents are brought out in parallel for the debug logic that consumes them.

Top module: `dbg_scan_chain`

## Requirements
- R1: The chain is selected only when `chain_i` equals CHAIN_ID (default 2) and `instr_i` equals INTEST_CODE (default 4'hC). While it is not selected, shift, update and capture strobes have no effect, the shift register keeps its contents, and `tdo_o` is 0.
- R2: The shift register is 38 bits long. Each selected shift cycle moves `tdi_i` into bit 37 and shifts the other bits down one place. `tdo_o` shows bit 0, so a word shifted in LSB first returns unchanged, LSB first, on the next 38 shift cycles.
- R3: A capture-DR strobe leaves the shift register unchanged.
- R4: On a selected update with bit 37 = 1 (write), register `bits[36:32]` of the bank takes `bits[31:0]` on that clock edge.
- R5: On a selected update with bit 37 = 0 (read), bits 31:0 of the shift register are loaded with the addressed register and bits 37:32 keep their value. The next 38 shift cycles return {0, address, data}.
- R6: Addresses at or above NUM_REGS (default 8) have no register behind them. They read as 0, and a write to them changes no register.
- R7: A low `rst_ni` clears the shift register to 0 and leaves the register bank unchanged.
- R8: A low `sys_rst_ni` clears every register in the bank to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | TAP reset, asynchronous, active low; clears the shift register |
| sys_rst_ni | input | 1 | System reset, asynchronous, active low; clears the register bank |
| capture_dr_i | input | 1 | TAP is in capture-DR |
| shift_dr_i | input | 1 | TAP is in shift-DR |
| update_dr_i | input | 1 | TAP is in update-DR |
| instr_i | input | IR_W (4) | Current TAP instruction |
| chain_i | input | CH_W (4) | Chain number chosen by the chain-select instruction |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, bit 0 of the shift register while selected |
| regs_o | output | NUM_REGS*32 | Register bank contents, register n in bits n*32 +: 32 |

## Verification
The assertions assume that the TAP drives no more than one of capture, shift and update in any cycle. They also assume that the instruction and chain number do not change in the middle of a shift sequence, as a real TAP state machine guarantees. The bench drives each strobe alone for whole cycles. It changes `instr_i` and `chain_i` only between complete 38-bit sequences, and it changes inputs only on the falling clock edge. Reset pulses are applied while every strobe is low, so each antecedent observes a quiet port.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int SR_W   = DATA_W + ADDR_W + 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } dbg_cmd_t;
endpackage

// File: rtl/dbg_chain_select.sv
module dbg_chain_select #(
  parameter int IR_W        = 4,
  parameter int CH_W        = 4,
  parameter int CHAIN_ID    = 2,
  parameter int INTEST_CODE = 12
) (
  input  logic [IR_W-1:0] instr_i,
  input  logic [CH_W-1:0] chain_i,
  output logic            sel_o
);
  localparam logic [IR_W-1:0] INTEST_V = IR_W'(INTEST_CODE);
  localparam logic [CH_W-1:0] CHAIN_V  = CH_W'(CHAIN_ID);

  assign sel_o = (instr_i == INTEST_V) && (chain_i == CHAIN_V);
endmodule

// File: rtl/dbg_chain_shreg.sv
module dbg_chain_shreg
  import dbg_chain_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output dbg_cmd_t          cmd_o
);
  logic [SR_W-1:0] sr_q;
  logic            rd_load;

  // shift has priority; the TAP never raises both
  assign rd_load = sel_i && update_i && !shift_i && !sr_q[SR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i && shift_i) begin
      sr_q <= {tdi_i, sr_q[SR_W-1:1]};
    end else if (rd_load) begin
      sr_q[DATA_W-1:0] <= rd_data_i;
    end
  end

  assign cmd_o = dbg_cmd_t'(sr_q);

  a_r1_idle_when_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(sr_q));

  a_r2_shift_moves_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && shift_i |=> (sr_q[SR_W-2:0] == $past(sr_q[SR_W-1:1]))
                         && (sr_q[SR_W-1] == $past(tdi_i)));

  a_r5_read_keeps_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load |=> sr_q[SR_W-1:DATA_W] == $past(sr_q[SR_W-1:DATA_W]));
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_chain_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_i && addr_i == ADDR_W'(g)) begin
        regs_q[g] <= wdata_i;
      end
    end

    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];

    a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(g) |=> regs_q[g] == $past(wdata_i));

    // R6: any write aimed elsewhere, mapped or not, leaves this register alone
    a_r6_untouched_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(g)) |=> $stable(regs_q[g]));
  end

  // unmapped addresses fall through to zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i)) rd_data_o = regs_q[i];
    end
  end
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain
  import dbg_chain_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int IR_W        = 4,
  parameter int CH_W        = 4,
  parameter int CHAIN_ID    = 2,
  parameter int INTEST_CODE = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sys_rst_ni,
  input  logic                       capture_dr_i,
  input  logic                       shift_dr_i,
  input  logic                       update_dr_i,
  input  logic [IR_W-1:0]            instr_i,
  input  logic [CH_W-1:0]            chain_i,
  input  logic                       tdi_i,
  output logic                       tdo_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic              sel;
  logic              bank_we;
  logic [DATA_W-1:0] rd_data;
  dbg_cmd_t          cmd;

  dbg_chain_select #(
    .IR_W(IR_W), .CH_W(CH_W), .CHAIN_ID(CHAIN_ID), .INTEST_CODE(INTEST_CODE)
  ) u_sel (
    .instr_i(instr_i),
    .chain_i(chain_i),
    .sel_o  (sel)
  );

  dbg_chain_shreg u_sr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel),
    .shift_i  (shift_dr_i),
    .update_i (update_dr_i),
    .tdi_i    (tdi_i),
    .rd_data_i(rd_data),
    .cmd_o    (cmd)
  );

  assign bank_we = sel && update_dr_i && !shift_dr_i && cmd.wr;

  dbg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_ni),
    .we_i     (bank_we),
    .addr_i   (cmd.addr),
    .wdata_i  (cmd.data),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );

  assign tdo_o = sel & cmd.data[0];

  a_r3_capture_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel && capture_dr_i && !shift_dr_i && !update_dr_i |=> $stable(cmd));

  a_r5_read_returns_reg: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    sel && update_dr_i && !shift_dr_i && !cmd.wr |=> cmd.data == $past(rd_data));

  a_r1_tdo_low_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |-> !tdo_o);
endmodule

// File: tb/sim_dbg_scan_chain.sv
module sim_dbg_scan_chain;
  localparam int NR = 8;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;   // write data, or expected read value
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 5'd0,  32'hA5A5_0001},
    '{1'b1, 5'd7,  32'h8000_00FF},
    '{1'b0, 5'd0,  32'hA5A5_0001},
    '{1'b0, 5'd7,  32'h8000_00FF},
    '{1'b1, 5'd12, 32'hDEAD_BEEF},
    '{1'b0, 5'd12, 32'h0000_0000},
    '{1'b0, 5'd3,  32'h0000_0000},
    '{1'b1, 5'd31, 32'h1234_5678}
  };

  logic clk = 1'b0, rst_n = 1'b0, sys_rst_n = 1'b0;
  logic cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [3:0] instr = 4'hC, chain = 4'd2;
  logic tdo;
  logic [NR*32-1:0] regs;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dbg_scan_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n),
    .capture_dr_i(cap), .shift_dr_i(sh), .update_dr_i(upd),
    .instr_i(instr), .chain_i(chain), .tdi_i(tdi), .tdo_o(tdo), .regs_o(regs)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [37:0] din, output logic [37:0] dout);
    sh = 1'b1;
    for (int i = 0; i < 38; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      @(posedge clk); @(negedge clk);
    end
    sh = 1'b0;
  endtask

  task automatic pulse(input int which);
    if (which == 0) upd = 1'b1; else cap = 1'b1;
    @(posedge clk); @(negedge clk);
    upd = 1'b0; cap = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [37:0] o;
    logic [NR*32-1:0] snap;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset bank", 64'(regs[63:0]), 64'h0);
    check("R7 reset tdo", 64'(tdo), 64'h0);

    // vector table: writes, reads, unmapped addresses
    foreach (VEC[k]) begin
      snap = regs;
      shift_word(VEC[k], o);
      pulse(0);
      if (VEC[k].wr) begin
        if (VEC[k].addr < NR) begin
          snap[VEC[k].addr*32 +: 32] = VEC[k].data;
          check("R4 write", 64'(regs[VEC[k].addr*32 +: 32]), 64'(VEC[k].data));
        end
        check("R6 bank after write", 64'(regs == snap), 64'h1);
      end else begin
        shift_word('0, o);
        check(VEC[k].addr < NR ? "R5 read" : "R6 unmapped read", 64'(o), 64'(VEC[k]));
      end
    end

    // R2: 38-bit length and LSB-first order
    shift_word(38'h2A_C0DE_F00D, o);
    shift_word(38'h15_1111_2222, o);
    check("R2 loopback", 64'(o), 64'h2A_C0DE_F00D);

    // R1: not selected by chain number
    snap = regs;
    chain = 4'd3;
    shift_word({1'b1, 5'd1, 32'hFFFF_FFFF}, o);
    check("R1 tdo low wrong chain", 64'(o), 64'h0);
    pulse(0);
    check("R1 no write wrong chain", 64'(regs == snap), 64'h1);
    chain = 4'd2;
    // R1: not selected by instruction
    instr = 4'h4;
    shift_word({1'b1, 5'd2, 32'h7777_7777}, o);
    check("R1 tdo low wrong instr", 64'(o), 64'h0);
    pulse(0);
    check("R1 no write wrong instr", 64'(regs == snap), 64'h1);
    instr = 4'hC;
    shift_word('0, o);
    check("R1 contents kept", 64'(o), 64'h15_1111_2222);

    // R3: capture between read load and shift-out
    shift_word({1'b1, 5'd2, 32'h1357_9BDF}, o);
    pulse(0);
    shift_word({1'b0, 5'd2, 32'h0}, o);
    pulse(0);
    pulse(1); pulse(1);
    shift_word('0, o);
    check("R3 capture inert", 64'(o), 64'({1'b0, 5'd2, 32'h1357_9BDF}));

    // R7: TAP reset clears shift register, keeps bank
    shift_word({1'b0, 5'd0, 32'h0}, o);
    pulse(0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    shift_word('0, o);
    check("R7 shreg cleared", 64'(o), 64'h0);
    check("R7 bank kept", 64'(regs[31:0]), 64'hA5A5_0001);

    // R8: system reset clears bank
    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    check("R8 bank cleared", 64'(regs == '0), 64'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule